// File: doc/BRIEF.md
# Memory-Mapped Physical Timer Channel

This block implements a single physical timer channel reached through two register frames that share one bus: a privileged base frame and an unprivileged mirror frame, chosen per access by a frame-select input. It watches a free-running 64-bit system count supplied from outside. It holds a 64-bit compare value and a small control register with an enable bit, a mask bit and a read-only status bit. It drives a level interrupt while the timer condition holds, the timer is enabled and the mask is clear.

Software can program the compare point in two ways. It can write the timer-value register with a signed 32-bit delay relative to the current count. It can also read that register back as a down-counting view of the time left. Two static permission inputs decide whether each frame can reach the registers. A denied access returns zero and its write has no effect. Clearing the enable bit silences the interrupt and forces status to read 0, while the down-count view keeps running.

Top module: `tmr_frame`

## Requirements
- R1: The control register holds enable in bit 0 and mask in bit 1. Bit 2 reads the status and ignores writes. Bits 31:3 always read 0 and ignore writes.
- R2: Status reads 1 exactly when enable is 1 and the signed 64-bit difference (count − compare) is ≥ 0. The mask bit has no effect on status.
- R3: The interrupt output is high exactly when status is 1 and mask is 0. With enable at 0 it is low.
- R4: The timer-value register reads the low 32 bits of (compare − count), and this view keeps moving while enable is 0. A write sets compare to count plus the sign-extended 32-bit written value, effective at the clock edge of the write.
- R5: The control register is at offset 0x02C and the timer-value register at offset 0x028 in both frames. Frame select 0 picks the base frame and 1 picks the unprivileged frame. Any other offset reads 0 and ignores writes.
- R6: In the base frame, both registers are reachable only while the base permission input is 1. Otherwise they read 0 and writes are ignored.
- R7: In the unprivileged frame, both registers are reachable only while the base permission and the unprivileged permission inputs are both 1. Otherwise they read 0 and writes are ignored.
- R8: After reset, enable and mask are 0, compare is all ones, and the interrupt is low.
- R9: The condition uses a wrap-safe signed difference. A compare value that has wrapped past 2^64 is treated as being in the future, not the past.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Free-running system count |
| perm_base | input | 1 | Base frame access permission |
| perm_user | input | 1 | Unprivileged frame enable (chained after perm_base) |
| bus_sel | input | 1 | Frame select: 0 base, 1 unprivileged |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed offset (combinational) |
| tmr_irq | output | 1 | Level timer interrupt |

## Verification
The bench visits all eight combinations of base permission, unprivileged permission and frame select. Each time it writes through the selected frame and reads the result back through a fully permitted frame. A design that only half-chains the permissions would leak writes from the unprivileged frame or hide legal ones. It puts the compare point at exactly the current count, one tick either side, and just past the 64-bit wrap. An off-by-one or unsigned comparison would fire the interrupt a tick early or late, or fire it at once after a wrap. It also advances the count with the timer disabled. A design that froze the down-count view, or leaked status or interrupt while disabled, would show a stale value or a spurious interrupt.

// File: rtl/tmr_frame.sv
module tmr_frame #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTL_OFS = 12'h02C,
  parameter logic [ADDR_W-1:0] TV_OFS  = 12'h028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              perm_base,
  input  logic              perm_user,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tmr_irq
);
  localparam int EXT_W = CNT_W - DATA_W;

  logic             en_q, mask_q;
  logic [CNT_W-1:0] cmp_q;
  logic             acc_ok, hit_ctl, hit_tv, cond, status;
  logic [DATA_W-1:0] tv_lo;

  assign acc_ok  = perm_base & (~bus_sel | perm_user);
  assign hit_ctl = acc_ok && (bus_addr == CTL_OFS);
  assign hit_tv  = acc_ok && (bus_addr == TV_OFS);
  assign cond    = ($signed(sys_count - cmp_q) >= 0);
  assign status  = en_q & cond;
  assign tmr_irq = status & ~mask_q;
  assign tv_lo   = DATA_W'(cmp_q - sys_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      cmp_q  <= '1;
    end else if (bus_wr) begin
      if (hit_ctl) begin
        en_q   <= bus_wdata[0];
        mask_q <= bus_wdata[1];
      end
      if (hit_tv)
        cmp_q <= sys_count + {{EXT_W{bus_wdata[DATA_W-1]}}, bus_wdata};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctl)     bus_rdata[2:0] = {status, mask_q, en_q};
    else if (hit_tv) bus_rdata      = tv_lo;
  end
endmodule

module tmr_frame_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTL_OFS = 12'h02C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              perm_base,
  input logic              perm_user,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              tmr_irq,
  input logic              en_q,
  input logic              mask_q,
  input logic [63:0]       cmp_q
);
  // R6
  base_deny_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perm_base |-> bus_rdata == 32'd0);
  // R7
  user_deny_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !perm_user) |-> bus_rdata == 32'd0);
  // R7
  deny_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !(perm_base && (!bus_sel || perm_user)))
      |=> ($stable(en_q) && $stable(mask_q) && $stable(cmp_q)));
  // R3
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !tmr_irq);
  // R3
  irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !tmr_irq);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTL_OFS) |-> bus_rdata[31:3] == 29'd0);
  // R2
  status_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == CTL_OFS) && !en_q) |-> !bus_rdata[2]);
endmodule

bind tmr_frame tmr_frame_chk #(.ADDR_W(ADDR_W), .CTL_OFS(CTL_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .perm_base(perm_base), .perm_user(perm_user),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tmr_irq(tmr_irq), .en_q(en_q), .mask_q(mask_q),
  .cmp_q(cmp_q)
);

// File: tb/test_tmr_frame.sv
module test_tmr_frame;
  localparam time CLK_P = 10;
  localparam logic [11:0] A_CTL = 12'h02C;
  localparam logic [11:0] A_TV  = 12'h028;

  logic clk = 0, rst_n = 0;
  logic [63:0] sys_count = 64'd100;
  logic perm_base = 1, perm_user = 1, bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tmr_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  tmr_frame i_tmr_frame (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic sel, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic sel, logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    rd(0, A_CTL, r); chk("R8 ctl", r, 0);
    chk("R8 irq", tmr_irq, 0);
    rd(0, A_TV, r); chk("R8 tv", r, 32'hFFFF_FFFF - 32'd100);
    // R5 unmapped offsets
    wr(0, 12'h030, 32'h3);
    rd(0, 12'h030, r); chk("R5 unmapped", r, 0);
    rd(0, A_CTL, r); chk("R5 unmapped write ignored", r, 0);

    // R6 R7 permission sweep
    for (int k = 0; k < 8; k++) begin
      logic pb, pu, sl, ok;
      logic [31:0] tvw;
      pb = k[0]; pu = k[1]; sl = k[2];
      ok = pb & (~sl | pu);
      tvw = 32'd500 + k;
      perm_base = 1; perm_user = 1;
      wr(0, A_CTL, 0);
      wr(0, A_TV, 32'd50);
      perm_base = pb; perm_user = pu;
      wr(sl, A_CTL, 32'h2);
      wr(sl, A_TV, tvw);
      rd(sl, A_CTL, r); chk($sformatf("R6 R7 ctl rd pb%0d pu%0d sel%0d", pb, pu, sl), r, ok ? 2 : 0);
      rd(sl, A_TV, r); chk($sformatf("R6 R7 tv rd pb%0d pu%0d sel%0d", pb, pu, sl), r, ok ? tvw : 0);
      perm_base = 1; perm_user = 1;
      rd(0, A_CTL, r); chk($sformatf("R6 R7 ctl wr effect k%0d", k), r, ok ? 2 : 0);
      rd(1, A_TV, r); chk($sformatf("R6 R7 tv wr effect k%0d", k), r, ok ? tvw : 50);
    end

    // R1 R2 R3 control sweep with boundary deltas
    sys_count = 64'd1000;
    for (int k = 0; k < 16; k++) begin
      logic en, mk, met;
      logic [31:0] dv;
      en = k[0]; mk = k[1];
      case (k[3:2])
        2'd0: dv = 32'd0;
        2'd1: dv = 32'd1;
        2'd2: dv = 32'hFFFF_FFFF;
        default: dv = 32'd20;
      endcase
      met = ($signed(dv) <= 0);
      wr(0, A_TV, dv);
      wr(1, A_CTL, 32'hFFFF_FFF8 | {30'd0, mk, en} | 32'h4);
      rd(1, A_CTL, r);
      chk($sformatf("R1 R2 ctl en%0d mk%0d dv%0d", en, mk, $signed(dv)), r, {29'd0, en & met, mk, en});
      chk($sformatf("R3 irq en%0d mk%0d dv%0d", en, mk, $signed(dv)), tmr_irq, en & met & ~mk);
    end

    // R4 view runs while disabled
    wr(0, A_CTL, 0);
    wr(0, A_TV, 32'd100);
    sys_count = 64'd1030;
    rd(0, A_TV, r); chk("R4 tv disabled", r, 32'd70);
    sys_count = 64'd1200;
    rd(0, A_TV, r); chk("R4 tv negative", r, 32'hFFFF_FF9C);
    chk("R3 irq disabled past compare", tmr_irq, 0);
    rd(0, A_CTL, r); chk("R2 status zero disabled", r, 0);
    wr(0, A_CTL, 32'h1);
    #1 chk("R3 irq after enable", tmr_irq, 1);
    rd(0, A_CTL, r); chk("R2 status after enable", r, 5);

    // R9 wrap
    sys_count = 64'hFFFF_FFFF_FFFF_FFF0;
    wr(0, A_TV, 32'h20);
    rd(0, A_CTL, r); chk("R9 wrap not met", r, 1);
    chk("R9 wrap irq", tmr_irq, 0);
    sys_count = 64'h10;
    rd(0, A_CTL, r); chk("R9 wrap reached", r, 5);
    chk("R9 wrap irq reached", tmr_irq, 1);
    sys_count = 64'h8;
    rd(0, A_TV, r); chk("R4 tv across wrap", r, 32'd8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule